// File: doc/BRIEF.md
# Programmable SPI Serial Clock Generator

This block derives the serial clock of a SPI flash controller from a faster system clock. A single 32-bit setting word controls it. One 6-bit field sets the period of the serial clock in system clocks. A second 6-bit field sets how long the clock stays high within each period. Because the high length is a separate count, the duty cycle stays close to half even when the period is an odd number of system clocks. A third 6-bit field is accepted and kept with the word, but it plays no part in the timing. A source-select bit is stored and presented on an output so that the surrounding clock logic can use it.

The transfer engine holds `run` high for the length of a transfer. At the start of each transfer the generator copies the stored setting into a working copy. A write that arrives while a transfer is in progress therefore changes nothing until the next start. The clock follows SPI mode 0: it idles low, the shift logic launches data on falling edges and captures it on rising edges. The generator tells the shift logic when to act with two one-cycle strobes, `launch_stb` and `sample_stb`. Every output is a flop.

Top module: `spi_sclk_gen`

## Requirements
- R1: After reset, `sclk`, `launch_stb`, `sample_stb` and `src_sel` are all 0.
- R2: A write with `cfg_we` high stores the divider from `cfg_wdata[17:12]` and the high count from `cfg_wdata[11:6]`. Bit 31 of the written word appears on `src_sel` from the cycle after the write. Bits 5:0 and bits 30:18 have no effect on any output.
- R3: For a stored divider n with 1 <= n <= 63, the serial clock period is n+1 system clocks. A stored divider of 0 behaves as 1, which gives a period of 2 system clocks.
- R4: With high count h, `sclk` is high for h+1 system clocks and low for n-h system clocks in each period. If h >= n, the generator uses h = n-1 instead, so the low phase always lasts at least one system clock.
- R5: While `run` is low, `sclk` is low. When `run` falls, `sclk` is low from the second clock edge at which `run` is sampled low.
- R6: `launch_stb` is high for exactly one system clock at the start of every period, including the first period of a transfer. That cycle is either the falling edge of `sclk` or the cycle in which the low phase begins.
- R7: `sample_stb` is high for exactly one system clock, in the first cycle of each high phase of `sclk`. `launch_stb` and `sample_stb` are never high together.
- R8: The generator copies the divider and high count when `run` is first sampled high after being low, and uses the value stored before that clock edge. A write during a transfer takes effect only at the next transfer start.
- R9: If `run` is first sampled high at edge k, `launch_stb` is high in the cycle that follows edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the setting word |
| cfg_wdata | input | 32 | Setting word to store |
| run | input | 1 | Transfer active, driven by the transfer engine |
| sclk | output | 1 | Serial clock, mode 0 (idles low) |
| launch_stb | output | 1 | One-cycle strobe at the start of each period (falling edge of `sclk`) |
| sample_stb | output | 1 | One-cycle strobe at each rising edge of `sclk` |
| src_sel | output | 1 | Stored source-select bit |

## Verification
A wrong phase count shows up on the ports within one serial period. A strobe lands in the wrong cycle, or the high or low run of `sclk` has the wrong length. Comparing the outputs every cycle catches this at the first misplaced edge. A working copy that is refreshed at the wrong time only shows once a mid-transfer write changes the period, so the stimulus writes during live transfers and then restarts. A generator that fails to stop shows `sclk` high during idle within two cycles after `run` falls.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

  // Divider actually used: a zero setting behaves as the minimum of one.
  function automatic int unsigned clamp_div(input int unsigned raw_div);
    return (raw_div == 0) ? 1 : raw_div;
  endfunction

  // High count actually used: capped so the low phase keeps at least one cycle.
  function automatic int unsigned clamp_high(input int unsigned raw_high,
                                             input int unsigned used_div);
    return (raw_high >= used_div) ? used_div - 1 : raw_high;
  endfunction

  // Phase index at which sclk rises (first cycle of the high phase).
  function automatic int unsigned rise_index(input int unsigned used_div,
                                             input int unsigned used_high);
    return used_div - used_high;
  endfunction

endpackage

// File: rtl/sclk_cfg_reg.sv
module sclk_cfg_reg #(
  parameter int DATA_W   = 32,
  parameter int CW       = 6,
  parameter int DIV_LSB  = 12,
  parameter int HIGH_LSB = 6,
  parameter int SRC_BIT  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [CW-1:0]     div_q,
  output logic [CW-1:0]     high_q,
  output logic              src_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      high_q <= '0;
      src_q  <= 1'b0;
    end else if (we) begin
      div_q  <= wdata[DIV_LSB +: CW];
      high_q <= wdata[HIGH_LSB +: CW];
      src_q  <= wdata[SRC_BIT];
    end
  end

endmodule

// File: rtl/sclk_phase_ctr.sv
module sclk_phase_ctr #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] cfg_div,
  input  logic [CW-1:0] cfg_high,
  output logic          active,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] act_div,
  output logic [CW-1:0] act_high,
  output logic          ld_start,
  output logic          wrap
);

  logic [CW-1:0] eff_div;
  logic [CW-1:0] eff_high;

  assign eff_div  = CW'(spi_sclk_pkg::clamp_div(int'(unsigned'(cfg_div))));
  assign eff_high = CW'(spi_sclk_pkg::clamp_high(int'(unsigned'(cfg_high)),
                                                 int'(unsigned'(eff_div))));

  assign ld_start = run && !active;
  assign wrap     = active && (cnt == act_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cnt      <= '0;
      act_div  <= CW'(1);
      act_high <= '0;
    end else if (!run) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (ld_start) begin
      active   <= 1'b1;
      cnt      <= '0;
      act_div  <= eff_div;
      act_high <= eff_high;
    end else if (wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] act_div,
  input  logic [CW-1:0] act_high,
  output logic          sclk_q,
  output logic          launch_q,
  output logic          sample_q
);

  logic [CW-1:0] rise_at;
  logic          sclk_d;
  logic          launch_d;
  logic          sample_d;

  assign rise_at  = CW'(spi_sclk_pkg::rise_index(int'(unsigned'(act_div)),
                                                 int'(unsigned'(act_high))));
  assign sclk_d   = active && (cnt >= rise_at);
  assign launch_d = active && (cnt == '0);
  assign sample_d = active && (cnt == rise_at);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      launch_q <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      sclk_q   <= sclk_d;
      launch_q <= launch_d;
      sample_q <= sample_d;
    end
  end

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int DATA_W   = 32,
  parameter int CW       = 6,
  parameter int DIV_LSB  = 12,
  parameter int HIGH_LSB = 6,
  parameter int SRC_BIT  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              run,
  output logic              sclk,
  output logic              launch_stb,
  output logic              sample_stb,
  output logic              src_sel
);

  localparam int DIV_MSB  = DIV_LSB + CW - 1;

  logic [CW-1:0] st_div;
  logic [CW-1:0] st_high;
  logic          ctr_active;
  logic [CW-1:0] ctr_cnt;
  logic [CW-1:0] act_div;
  logic [CW-1:0] act_high;
  logic          ld_start;
  logic          ctr_wrap;
  logic          unused_bits;

  // Fields that carry no timing meaning here.
  assign unused_bits = ^{cfg_wdata[SRC_BIT-1:DIV_MSB+1], cfg_wdata[HIGH_LSB-1:0]};

  sclk_cfg_reg #(
    .DATA_W(DATA_W), .CW(CW), .DIV_LSB(DIV_LSB),
    .HIGH_LSB(HIGH_LSB), .SRC_BIT(SRC_BIT)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .div_q(st_div), .high_q(st_high), .src_q(src_sel)
  );

  sclk_phase_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .run(run),
    .cfg_div(st_div), .cfg_high(st_high),
    .active(ctr_active), .cnt(ctr_cnt),
    .act_div(act_div), .act_high(act_high),
    .ld_start(ld_start), .wrap(ctr_wrap)
  );

  sclk_edge_gen #(.CW(CW)) u_edge (
    .clk(clk), .rst_n(rst_n), .active(ctr_active), .cnt(ctr_cnt),
    .act_div(act_div), .act_high(act_high),
    .sclk_q(sclk), .launch_q(launch_stb), .sample_q(sample_stb)
  );

endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          sclk,
  input logic          launch_stb,
  input logic          sample_stb,
  input logic          active,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] act_div,
  input logic          ld_start,
  input logic          wrap
);

  assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run)) |=> !sclk);

  assert_launch_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    launch_stb |-> !sclk);

  assert_launch_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    launch_stb |=> !launch_stb);

  assert_sample_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (sclk && !$past(sclk)));

  assert_sample_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch_stb && sample_stb));

  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ld_start && run) |=> $stable(act_div));

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= act_div));

  assert_wrap_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && run) |=> (cnt == '0));

endmodule

bind spi_sclk_gen sclk_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .sclk(sclk),
  .launch_stb(launch_stb), .sample_stb(sample_stb),
  .active(ctr_active), .cnt(ctr_cnt), .act_div(act_div),
  .ld_start(ld_start), .wrap(ctr_wrap)
);

// File: tb/spi_sclk_gen_tb.sv
module spi_sclk_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        run = 1'b0;
  logic        sclk, launch_stb, sample_stb, src_sel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit cmp_en = 1'b0;
  string tag = "R1";

  always #4 clk = ~clk;

  spi_sclk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .run(run), .sclk(sclk), .launch_stb(launch_stb),
    .sample_stb(sample_stb), .src_sel(src_sel)
  );

  // Behavioural reference model, updated on each rising edge.
  int m_on = 0, m_ph = 0, m_per = 2, m_hi = 1;
  int s_n = 0, s_h = 0, s_src = 0;
  int e_sclk = 0, e_l = 0, e_s = 0, e_src = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_on = 0; m_ph = 0; s_n = 0; s_h = 0; s_src = 0;
      e_sclk = 0; e_l = 0; e_s = 0; e_src = 0;
    end else begin
      // outputs reflect the phase before this edge; low part comes first
      e_l    = (m_on != 0 && m_ph == 0) ? 1 : 0;
      e_sclk = (m_on != 0 && m_ph >= m_per - m_hi) ? 1 : 0;
      e_s    = (m_on != 0 && m_ph == m_per - m_hi) ? 1 : 0;
      if (!run) begin
        m_on = 0; m_ph = 0;
      end else if (m_on == 0) begin
        m_on = 1; m_ph = 0;
        m_per = (s_n < 1 ? 1 : s_n) + 1;            // period in system clocks
        m_hi  = (s_h + 1 > m_per - 1) ? m_per - 1 : s_h + 1;  // high cycles
      end else begin
        m_ph = (m_ph + 1) % m_per;
      end
      if (cfg_we) begin
        s_n = int'(cfg_wdata[17:12]);
        s_h = int'(cfg_wdata[11:6]);
        s_src = int'(cfg_wdata[31]);
      end
      e_src = s_src;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(tag, int'(sclk), e_sclk, "sclk");
      chk(tag, int'(launch_stb), e_l, "launch_stb");
      chk(tag, int'(sample_stb), e_s, "sample_stb");
      chk(tag, int'(src_sel), e_src, "src_sel");
    end
  end

  task automatic wcfg(input int n, input int h, input int lowf, input int src, input int junk);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = '0;
    cfg_wdata[17:12] = 6'(n);
    cfg_wdata[11:6]  = 6'(h);
    cfg_wdata[5:0]   = 6'(lowf);
    cfg_wdata[31]    = 1'(src);
    cfg_wdata[30:18] = 13'(junk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic burst(input int k);
    @(negedge clk); run = 1'b1;
    idle(k);
    run = 1'b0;
    idle(4);
  endtask

  // Measure spacing of sample strobes and length of the high run.
  task automatic measure(input int exp_per, input int exp_hi, input string req);
    int t;
    int hi;
    t = 0;
    while (sample_stb !== 1'b1 && t < 300) begin @(negedge clk); t++; end
    t = 0; hi = 0;
    do begin
      if (sclk === 1'b1) hi++;
      @(negedge clk); t++;
    end while (sample_stb !== 1'b1 && t < 300);
    chk(req, t, exp_per, "period in system clocks");
    chk(req, hi, exp_hi, "high cycles per period");
  endtask

  initial begin
    idle(3);
    // R1 reset state
    chk("R1", int'(sclk), 0, "sclk at reset");
    chk("R1", int'(launch_stb), 0, "launch_stb at reset");
    chk("R1", int'(sample_stb), 0, "sample_stb at reset");
    chk("R1", int'(src_sel), 0, "src_sel at reset");
    @(negedge clk); rst_n = 1'b1;
    cmp_en = 1'b1;

    // R2 field decode, source bit and ignored bits; R3 minimum divider
    tag = "R2";
    wcfg(1, 0, 63, 1, 8191);
    chk("R2", int'(src_sel), 1, "src_sel after write");
    tag = "R3";
    burst(20);

    // R9 start latency
    tag = "R9";
    @(negedge clk); run = 1'b1;
    @(negedge clk);
    chk("R9", int'(launch_stb), 0, "launch one cycle after start edge");
    @(negedge clk);
    chk("R9", int'(launch_stb), 1, "launch two cycles after start edge");
    run = 1'b0; idle(4);

    // R3/R4 odd period, near-half duty
    tag = "R4";
    wcfg(5, 2, 5, 0, 0);
    @(negedge clk); run = 1'b1;
    measure(6, 3, "R3");
    measure(6, 3, "R4");
    run = 1'b0; idle(4);

    // R3 zero divider acts as one
    tag = "R3";
    wcfg(0, 0, 0, 0, 0);
    @(negedge clk); run = 1'b1;
    measure(2, 1, "R3");
    run = 1'b0; idle(4);

    // R4 high count clamp
    tag = "R4";
    wcfg(4, 7, 4, 1, 5);
    @(negedge clk); run = 1'b1;
    measure(5, 4, "R4");
    run = 1'b0; idle(4);

    // R3 largest period
    tag = "R3";
    wcfg(63, 31, 63, 0, 0);
    burst(200);

    // R8 mid-transfer write held until next start
    tag = "R8";
    wcfg(3, 1, 3, 0, 0);
    @(negedge clk); run = 1'b1;
    idle(6);
    cfg_we = 1'b1; cfg_wdata = '0; cfg_wdata[17:12] = 6'd7; cfg_wdata[11:6] = 6'd3;
    @(negedge clk); cfg_we = 1'b0;
    measure(4, 2, "R8");
    run = 1'b0; idle(3);
    @(negedge clk); run = 1'b1;
    measure(8, 4, "R8");

    // R5 stop during high phase
    tag = "R5";
    while (sclk !== 1'b1) @(negedge clk);
    run = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R5", int'(sclk), 0, "sclk after stop");
    idle(10);

    // R6/R7 strobes under back-to-back restarts
    tag = "R6";
    wcfg(2, 0, 2, 0, 0);
    burst(15);
    tag = "R7";
    burst(9);

    cmp_en = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule